// File: doc/BRIEF.md
# Channel Address Interleave Reducer

This block turns a system physical address, already steered to one memory controller and one channel, into the address as that channel sees it. Each controller holds a table of up to eight address windows. A window is described by a start word and a shape word, and every window also has one displacement word per channel. The first enabled window that covers the request is the one that is used. Its displacement is subtracted, and then the socket-level and channel-level interleave are taken out. Each of these two steps divides the address bits above a chosen granularity position by a way count and keeps the bits below that position.

Requests enter on a valid/ready stream and results leave on another one. Only one request is in flight at a time. The input side reports ready only while the block is idle. A result stays on the output, unchanged, until the consumer takes it. A way count of 1, 2, 4 or 8 is removed with a shift and finishes in one cycle. A way count of 3 goes through a radix-2 restoring divider that handles one quotient bit per cycle, so that step takes as many cycles as the address is wide. The tables are loaded through a plain write port, and software should write them only while the block is idle.

Top module: `ilv_reducer`

## Requirements
- R1: A window matches when start <= address <= end. The start is bits 31:12 of the start word followed by 26 zero bits. The end is bits 31:12 of the shape word followed by 26 one bits. When several windows match, the one with the lowest index is used.
- R2: The socket granularity code sits in start-word bits 5:4 and the channel granularity code sits in bits 7:6. Codes 0, 1, 2 and 3 select bit positions 6, 8, 12 and 30.
- R3: The socket way count is 1 shifted left by shape-word bits 11:10, giving 1, 2, 4 or 8. The channel way count is shape-word bits 9:8 plus one, giving 1 to 4. On a hit, both counts are reported on `out_skt_ways` and `out_chn_ways`.
- R4: The displacement is bits 23:4 of the displacement word for the selected controller, channel and window, followed by 26 zero bits. It is subtracted from the address, modulo 2^46, before interleave removal.
- R5: One removal step with granularity g, way count w and low-bit source L produces (floor((v >> g) / w) << g) | (L mod 2^g). This holds for w = 3 as well as for powers of two.
- R6: The order of the steps depends on the window. If the channel way count is 3 and the socket bit is strictly above the channel bit, the channel step runs first, then the socket step, and each step takes its low bits from its own input value. Otherwise the socket step runs first, then the channel step, and both take their low bits from the original request address.
- R7: When no window matches, the result has `out_hit` = 0, `out_chan_addr` = 0 and both way counts = 0.
- R8: `in_ready` is high only while no request is in flight. A request is taken on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` stays low while a result is waiting.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every result field hold steady.
- R10: A table write happens when `cfg_wr_en` is high. `cfg_wr_sel` selects the table: 0 = start word, 1 = shape word, 2 = displacement word. The start and shape words are indexed by controller and window, and `cfg_wr_chan` is ignored for them. The displacement word is indexed by controller, channel and window. A lookup reads only the tables of its own controller.
- R11: After reset, `in_ready` = 1, `out_valid` = 0, and every table word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | 46 | System address |
| in_ctrl | input | 1 | Controller index |
| in_chan | input | 2 | Channel index |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_sel | input | 2 | Table select (0 start, 1 shape, 2 displacement) |
| cfg_wr_ctrl | input | 1 | Controller of the written word |
| cfg_wr_chan | input | 2 | Channel of a displacement word |
| cfg_wr_entry | input | 3 | Window index |
| cfg_wr_data | input | 32 | Word to write |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A window matched |
| out_chan_addr | output | 46 | Channel-local address |
| out_skt_ways | output | 4 | Socket way count |
| out_chn_ways | output | 3 | Channel way count |

## Verification
The stimulus covers the following cases:
- A 2-way socket split at bit 6.
- A 3-way channel split whose socket bit sits above the channel bit, which forces the channel-first order.
- A 3-way channel split with a 4-way socket split at a lower bit, which keeps the socket-first order while the division by 3 still runs.
- Two matching windows that overlap, a case only the lowest-index rule separates.
- An 8-way socket split at bit 30.
- A 3-way split at bit 30.

A window's exact start and exact end, together with the addresses just outside them, show any off-by-one in the range compare. A displacement that is non-zero on one channel only shows that the channel index selects the word. The same address sent to the other controller shows that the tables are kept separate. A result held under back-pressure is watched for several cycles to confirm that it does not change.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
  localparam int FIELD_W = 20;
  localparam int BLK_SH  = 26;
  localparam int ADDR_W  = FIELD_W + BLK_SH;
  localparam int WORD_W  = 32;
  localparam int GBIT_W  = 5;
  localparam int WAYS_W  = 4;

  typedef enum logic [1:0] {
    TBL_BASE = 2'd0,
    TBL_SHAPE = 2'd1,
    TBL_DISP = 2'd2
  } tbl_sel_e;

  function automatic logic [GBIT_W-1:0] gran_pos(input logic [1:0] code);
    case (code)
      2'd0: return GBIT_W'(6);
      2'd1: return GBIT_W'(8);
      2'd2: return GBIT_W'(12);
      default: return GBIT_W'(30);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] low_mask(input logic [GBIT_W-1:0] g);
    return (ADDR_W'(1) << g) - ADDR_W'(1);
  endfunction
endpackage

// File: rtl/ilv_tables.sv
`timescale 1ns/1ps
module ilv_tables
  import ilv_pkg::*;
#(
  parameter int NCTRL = 2,
  parameter int NCHAN = 3,
  parameter int NENT = 8,
  parameter int CTRL_W = (NCTRL > 1) ? $clog2(NCTRL) : 1,
  parameter int CHAN_W = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  parameter int ENT_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [ENT_W-1:0]  wr_ent,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CTRL_W-1:0] rd_ctrl,
  input  logic [CHAN_W-1:0] rd_chan,
  output logic [WORD_W-1:0] base_o [NENT],
  output logic [WORD_W-1:0] shape_o [NENT],
  output logic [WORD_W-1:0] disp_o [NENT]
);
  logic [WORD_W-1:0] base_q  [NCTRL][NENT];
  logic [WORD_W-1:0] shape_q [NCTRL][NENT];
  logic [WORD_W-1:0] disp_q  [NCTRL][NCHAN][NENT];

  logic wr_ok_ctrl, wr_ok_chan, wr_ok_ent;
  assign wr_ok_ctrl = int'(wr_ctrl) < NCTRL;
  assign wr_ok_chan = int'(wr_chan) < NCHAN;
  assign wr_ok_ent  = int'(wr_ent) < NENT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTRL; c++) begin
        for (int e = 0; e < NENT; e++) begin
          base_q[c][e]  <= '0;
          shape_q[c][e] <= '0;
          for (int h = 0; h < NCHAN; h++) disp_q[c][h][e] <= '0;
        end
      end
    end else if (wr_en && wr_ok_ctrl && wr_ok_ent) begin
      case (tbl_sel_e'(wr_sel))
        TBL_BASE:  base_q[wr_ctrl][wr_ent] <= wr_data;
        TBL_SHAPE: shape_q[wr_ctrl][wr_ent] <= wr_data;
        TBL_DISP:  if (wr_ok_chan) disp_q[wr_ctrl][wr_chan][wr_ent] <= wr_data;
        default: ;
      endcase
    end
  end

  logic rd_ok;
  assign rd_ok = (int'(rd_ctrl) < NCTRL) && (int'(rd_chan) < NCHAN);

  generate
    for (genvar e = 0; e < NENT; e++) begin : g_rd
      assign base_o[e]  = rd_ok ? base_q[rd_ctrl][e] : '0;
      assign shape_o[e] = rd_ok ? shape_q[rd_ctrl][e] : '0;
      assign disp_o[e]  = rd_ok ? disp_q[rd_ctrl][rd_chan][e] : '0;
    end
  endgenerate
endmodule

// File: rtl/ilv_match.sv
`timescale 1ns/1ps
module ilv_match
  import ilv_pkg::*;
#(
  parameter int NENT = 8,
  parameter int ENT_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] base_i [NENT],
  input  logic [WORD_W-1:0] shape_i [NENT],
  output logic              hit,
  output logic [ENT_W-1:0]  idx
);
  logic [NENT-1:0] inr;
  logic [NENT-1:0] unused_low;

  generate
    for (genvar e = 0; e < NENT; e++) begin : g_cmp
      logic [ADDR_W-1:0] lo, hi;
      assign lo = {base_i[e][31:12], {BLK_SH{1'b0}}};
      assign hi = {shape_i[e][31:12], {BLK_SH{1'b1}}};
      assign inr[e] = (lo <= addr) && (addr <= hi);
      assign unused_low[e] = ^{base_i[e][11:0], shape_i[e][11:0]};
    end
  endgenerate

  always_comb begin
    hit = |inr;
    idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (inr[e]) idx = ENT_W'(e);
    end
  end
endmodule

// File: rtl/ilv_remove.sv
`timescale 1ns/1ps
module ilv_remove
  import ilv_pkg::*;
#(
  parameter int CNT_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] value,
  input  logic [GBIT_W-1:0] gran,
  input  logic [WAYS_W-1:0] ways,
  input  logic [ADDR_W-1:0] low_src,
  output logic              done,
  output logic [ADDR_W-1:0] result
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] work_q;
  logic [1:0]        rem_q;
  logic [GBIT_W-1:0] gran_q;
  logic [ADDR_W-1:0] low_q;

  logic [2:0] trial;
  logic       qbit;
  logic [1:0] rem_nxt;
  logic [ADDR_W-1:0] work_nxt;
  assign trial    = {rem_q, work_q[ADDR_W-1]};
  assign qbit     = trial >= 3'd3;
  assign rem_nxt  = qbit ? 2'(trial - 3'd3) : trial[1:0];
  assign work_nxt = {work_q[ADDR_W-2:0], qbit};

  logic [1:0] lg;
  always_comb begin
    case (ways)
      4'd2: lg = 2'd1;
      4'd4: lg = 2'd2;
      4'd8: lg = 2'd3;
      default: lg = 2'd0;
    endcase
  end
  logic [5:0] sh_tot;
  assign sh_tot = 6'(gran) + 6'(lg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      work_q <= '0;
      rem_q  <= '0;
      gran_q <= '0;
      low_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        gran_q <= gran;
        low_q  <= low_src;
        if (ways == 4'd3) begin
          work_q <= value >> gran;
          rem_q  <= '0;
          cnt_q  <= CNT_W'(ADDR_W);
          busy_q <= 1'b1;
        end else begin
          result <= ((value >> sh_tot) << gran) | (low_src & low_mask(gran));
          done   <= 1'b1;
        end
      end else if (busy_q) begin
        work_q <= work_nxt;
        rem_q  <= rem_nxt;
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          result <= (work_nxt << gran_q) | (low_q & low_mask(gran_q));
        end
      end
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> rem_q != 2'd3); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start); // R5
endmodule

// File: rtl/ilv_reducer.sv
`timescale 1ns/1ps
module ilv_reducer
  import ilv_pkg::*;
#(
  parameter int NCTRL = 2,
  parameter int NCHAN = 3,
  parameter int NENT = 8,
  parameter int CTRL_W = (NCTRL > 1) ? $clog2(NCTRL) : 1,
  parameter int CHAN_W = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  parameter int ENT_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [CTRL_W-1:0] cfg_wr_ctrl,
  input  logic [CHAN_W-1:0] cfg_wr_chan,
  input  logic [ENT_W-1:0]  cfg_wr_entry,
  input  logic [WORD_W-1:0] cfg_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [ADDR_W-1:0] out_chan_addr,
  output logic [3:0]        out_skt_ways,
  output logic [2:0]        out_chn_ways
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_STEP1, S_WAIT1, S_STEP2, S_WAIT2, S_DONE
  } st_e;
  st_e state;

  logic [ADDR_W-1:0] addr_q, chaddr_q, mid_q, res_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CHAN_W-1:0] chan_q;
  logic [GBIT_W-1:0] sg_q, cg_q;
  logic [3:0]        sktw_q;
  logic [2:0]        chnw_q;
  logic              chfirst_q, hit_q;

  logic [WORD_W-1:0] base_w [NENT];
  logic [WORD_W-1:0] shape_w [NENT];
  logic [WORD_W-1:0] disp_w [NENT];

  ilv_tables #(.NCTRL(NCTRL), .NCHAN(NCHAN), .NENT(NENT),
               .CTRL_W(CTRL_W), .CHAN_W(CHAN_W), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_ctrl(cfg_wr_ctrl),
    .wr_chan(cfg_wr_chan), .wr_ent(cfg_wr_entry), .wr_data(cfg_wr_data),
    .rd_ctrl(ctrl_q), .rd_chan(chan_q),
    .base_o(base_w), .shape_o(shape_w), .disp_o(disp_w)
  );

  logic             m_hit;
  logic [ENT_W-1:0] m_idx;
  ilv_match #(.NENT(NENT), .ENT_W(ENT_W)) u_match (
    .addr(addr_q), .base_i(base_w), .shape_i(shape_w),
    .hit(m_hit), .idx(m_idx)
  );

  logic [WORD_W-1:0] sel_base, sel_shape, sel_disp;
  assign sel_base  = base_w[m_idx];
  assign sel_shape = shape_w[m_idx];
  assign sel_disp  = disp_w[m_idx];

  logic unused_fields;
  assign unused_fields = ^{sel_base[31:8], sel_base[3:0], sel_shape[31:12],
                           sel_shape[7:0], sel_disp[31:24], sel_disp[3:0]};

  logic [GBIT_W-1:0] sg_n, cg_n;
  assign sg_n = gran_pos(sel_base[5:4]);
  assign cg_n = gran_pos(sel_base[7:6]);

  // Step operand selection
  logic              rm_start, rm_done;
  logic [ADDR_W-1:0] rm_value, rm_low, rm_result;
  logic [GBIT_W-1:0] rm_gran;
  logic [WAYS_W-1:0] rm_ways;
  logic              chan_step;

  always_comb begin
    rm_start  = (state == S_STEP1) || (state == S_STEP2);
    rm_value  = (state == S_STEP2) ? mid_q : chaddr_q;
    chan_step = (state == S_STEP2) ^ chfirst_q;
    rm_gran   = chan_step ? cg_q : sg_q;
    rm_ways   = chan_step ? WAYS_W'(chnw_q) : WAYS_W'(sktw_q);
    rm_low    = chfirst_q ? rm_value : addr_q;
  end

  ilv_remove u_rm (
    .clk(clk), .rst_n(rst_n), .start(rm_start), .value(rm_value),
    .gran(rm_gran), .ways(rm_ways), .low_src(rm_low),
    .done(rm_done), .result(rm_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      ctrl_q    <= '0;
      chan_q    <= '0;
      chaddr_q  <= '0;
      mid_q     <= '0;
      res_q     <= '0;
      sg_q      <= '0;
      cg_q      <= '0;
      sktw_q    <= '0;
      chnw_q    <= '0;
      chfirst_q <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          addr_q <= in_addr;
          ctrl_q <= in_ctrl;
          chan_q <= in_chan;
          state  <= S_LOOK;
        end
        S_LOOK: begin
          if (m_hit) begin
            hit_q     <= 1'b1;
            chaddr_q  <= addr_q - {sel_disp[23:4], {BLK_SH{1'b0}}};
            sg_q      <= sg_n;
            cg_q      <= cg_n;
            sktw_q    <= 4'd1 << sel_shape[11:10];
            chnw_q    <= {1'b0, sel_shape[9:8]} + 3'd1;
            chfirst_q <= (sel_shape[9:8] == 2'd2) && (sg_n > cg_n);
            state     <= S_STEP1;
          end else begin
            hit_q  <= 1'b0;
            res_q  <= '0;
            sktw_q <= '0;
            chnw_q <= '0;
            state  <= S_DONE;
          end
        end
        S_STEP1: state <= S_WAIT1;
        S_WAIT1: if (rm_done) begin
          mid_q <= rm_result;
          state <= S_STEP2;
        end
        S_STEP2: state <= S_WAIT2;
        S_WAIT2: if (rm_done) begin
          res_q <= rm_result;
          state <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready      = (state == S_IDLE);
  assign out_valid     = (state == S_DONE);
  assign out_hit       = hit_q;
  assign out_chan_addr = res_q;
  assign out_skt_ways  = sktw_q;
  assign out_chn_ways  = chnw_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan_addr) && $stable(out_hit)
      && $stable(out_skt_ways) && $stable(out_chn_ways)); // R9
  AST_NO_READY_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_chan_addr == '0 && out_skt_ways == 4'd0
      && out_chn_ways == 3'd0); // R7
  AST_WAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> $countones(out_skt_ways) == 1
      && out_chn_ways >= 3'd1 && out_chn_ways <= 3'd4); // R3
endmodule

// File: tb/sim_ilv_reducer.sv
`timescale 1ns/1ps
module sim_ilv_reducer;
  import ilv_pkg::*;
  localparam int NCTRL = 2;
  localparam int NCHAN = 3;
  localparam int NENT = 8;
  localparam longint unsigned AMASK = (64'd1 << ADDR_W) - 64'd1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, in_valid, in_ready, cfg_wr_en, out_valid, out_ready, out_hit;
  logic [ADDR_W-1:0] in_addr, out_chan_addr;
  logic [0:0]        in_ctrl, cfg_wr_ctrl;
  logic [1:0]        in_chan, cfg_wr_sel, cfg_wr_chan;
  logic [2:0]        cfg_wr_entry, out_chn_ways;
  logic [31:0]       cfg_wr_data;
  logic [3:0]        out_skt_ways;

  ilv_reducer #(.NCTRL(NCTRL), .NCHAN(NCHAN), .NENT(NENT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_ctrl(in_ctrl), .in_chan(in_chan),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_ctrl(cfg_wr_ctrl),
    .cfg_wr_chan(cfg_wr_chan), .cfg_wr_entry(cfg_wr_entry), .cfg_wr_data(cfg_wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_chan_addr(out_chan_addr), .out_skt_ways(out_skt_ways), .out_chn_ways(out_chn_ways)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  logic [31:0] mb [NCTRL][NENT];
  logic [31:0] mw [NCTRL][NENT];
  logic [31:0] mo [NCTRL][NCHAN][NENT];

  typedef struct {
    logic hit;
    longint unsigned ca;
    int sw;
    int cw;
  } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int gmap(input logic [1:0] c);
    case (c)
      2'd0: return 6;
      2'd1: return 8;
      2'd2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic longint unsigned strip(input longint unsigned v, input int g,
                                            input int w, input longint unsigned low);
    longint unsigned q;
    q = (v >> g) / longint'(w);
    return ((q << g) | (low & ((64'd1 << g) - 64'd1))) & AMASK;
  endfunction

  // Reference model built from R1..R7
  function automatic exp_t model(input longint unsigned a, input int c, input int ch);
    exp_t r;
    int sel;
    longint unsigned lo, hi, ca, mid;
    int sg, cg;
    r.hit = 1'b0; r.ca = 0; r.sw = 0; r.cw = 0;
    sel = -1;
    for (int e = NENT - 1; e >= 0; e--) begin
      lo = longint'(mb[c][e][31:12]) << 26;
      hi = (longint'(mw[c][e][31:12]) << 26) | 64'h3FF_FFFF;
      if (lo <= a && a <= hi) sel = e;
    end
    if (sel < 0) return r;
    r.hit = 1'b1;
    sg = gmap(mb[c][sel][5:4]);
    cg = gmap(mb[c][sel][7:6]);
    r.sw = 1 << mw[c][sel][11:10];
    r.cw = int'(mw[c][sel][9:8]) + 1;
    ca = (a - (longint'(mo[c][ch][sel][23:4]) << 26)) & AMASK;
    if (r.cw == 3 && sg > cg) begin
      mid  = strip(ca, cg, r.cw, ca);
      r.ca = strip(mid, sg, r.sw, mid);
    end else begin
      mid  = strip(ca, sg, r.sw, a);
      r.ca = strip(mid, cg, r.cw, a);
    end
    return r;
  endfunction

  // R10: write port, sel 0 start, 1 shape, 2 displacement
  task automatic wr(input int sel, input int c, input int ch, input int e, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_sel = 2'(sel); cfg_wr_ctrl = 1'(c); cfg_wr_chan = 2'(ch);
    cfg_wr_entry = 3'(e); cfg_wr_data = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (sel == 0) mb[c][e] = d;
    else if (sel == 1) mw[c][e] = d;
    else mo[c][ch][e] = d;
  endtask

  task automatic win(input int c, input int e, input logic [19:0] b, input logic [19:0] l,
                     input logic [1:0] sgc, input logic [1:0] cgc,
                     input logic [1:0] swc, input logic [1:0] cwc);
    wr(0, c, 0, e, {b, 4'h0, cgc, sgc, 4'h0});
    wr(1, c, 0, e, {l, swc, cwc, 8'h00});
  endtask

  task automatic send(input longint unsigned a, input int c, input int ch, input string tag);
    exp_q.push_back(model(a, c, ch));
    tag_q.push_back(tag);
    @(negedge clk);
    in_addr = ADDR_W'(a); in_ctrl = 1'(c); in_chan = 2'(ch); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected result", out_chan_addr, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_hit == e.hit, t, "hit", out_hit, e.hit);
        check(out_chan_addr == ADDR_W'(e.ca), t, "chan_addr", out_chan_addr, e.ca);
        check(int'(out_skt_ways) == e.sw && int'(out_chn_ways) == e.cw, t, "ways",
              {out_skt_ways, 4'h0, 1'b0, out_chn_ways}, (e.sw << 8) | e.cw);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #800000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    longint unsigned hold_a;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_ctrl = '0; in_chan = '0;
    cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_ctrl = '0; cfg_wr_chan = '0;
    cfg_wr_entry = '0; cfg_wr_data = '0; out_ready = 1'b1;
    for (int c = 0; c < NCTRL; c++)
      for (int e = 0; e < NENT; e++) begin
        mb[c][e] = '0; mw[c][e] = '0;
        for (int h = 0; h < NCHAN; h++) mo[c][h][e] = '0;
      end
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R11", "idle after reset",
          {in_ready, out_valid}, 2'b10);
    // R11: zeroed tables make window 0 cover [0, 2^26)
    send(64'h0123_4567, 0, 1, "R11");

    // park every window out of reach
    for (int c = 0; c < NCTRL; c++)
      for (int e = 0; e < NENT; e++) begin
        wr(0, c, 0, e, 32'hFFFF_F000);
        wr(1, c, 0, e, 32'h0000_0000);
      end
    // controller 0 windows
    win(0, 0, 20'h00000, 20'h00003, 2'd0, 2'd1, 2'd1, 2'd0); // skt 2-way @6
    win(0, 1, 20'h00004, 20'h0000F, 2'd2, 2'd0, 2'd0, 2'd2); // chan 3-way, skt bit higher
    win(0, 2, 20'h00010, 20'h0001F, 2'd0, 2'd1, 2'd2, 2'd2); // skt 4 @6, chan 3 @8
    win(0, 3, 20'h00020, 20'h0003F, 2'd3, 2'd2, 2'd3, 2'd3); // skt 8 @30, chan 4 @12
    win(0, 4, 20'h00020, 20'h0002F, 2'd0, 2'd0, 2'd0, 2'd0); // overlaps window 3
    win(0, 5, 20'h00100, 20'h001FF, 2'd1, 2'd3, 2'd0, 2'd2); // chan 3 @30
    wr(2, 0, 2, 1, {8'h00, 20'h00002, 4'h0});
    wr(2, 0, 1, 5, {8'h00, 20'h00010, 4'h0});
    // controller 1
    win(1, 0, 20'h00000, 20'h000FF, 2'd0, 2'd0, 2'd0, 2'd2); // chan 3 @6, equal bits

    send(64'h0ABC_DEF4, 0, 0, "R5");
    send(64'h1000_0000, 0, 0, "R1");
    send(64'h3FFF_FFFF, 0, 2, "R4");
    send(64'h2345_6789, 0, 2, "R6");
    send(64'h2345_6789, 0, 0, "R6");
    send(64'h5A5A_5A5A, 0, 0, "R6");
    send(64'h9876_5432, 0, 0, "R1");
    send(64'hF00D_BEEF, 0, 1, "R2");
    send(64'h2_0000_0000, 0, 0, "R7");
    send(64'h3_FFFF_FFFF, 0, 0, "R1");
    send(64'h4_0000_0000, 0, 1, "R4");
    send(64'h7_1234_5678, 0, 1, "R4");
    send(64'h7_1234_5678, 0, 0, "R2");
    send(64'h0ABC_DEF4, 1, 0, "R10");
    send(64'h5_0000_0000, 1, 0, "R7");
    send(64'h3FFF_FFFF_FFFF, 0, 0, "R7");
    send(64'h1_2345_6789, 1, 2, "R3");

    // R8 / R9: back-pressure on a long 3-way request
    while (exp_q.size() != 0) @(negedge clk);
    out_ready = 1'b0;
    send(64'h2_468A_CE13, 1, 1, "R9");
    while (!out_valid) @(negedge clk);
    hold_a = out_chan_addr;
    repeat (6) @(negedge clk);
    check(out_valid == 1'b1, "R9", "valid held", out_valid, 1);
    check(out_chan_addr == ADDR_W'(hold_a), "R9", "addr held", out_chan_addr, hold_a);
    check(in_ready == 1'b0, "R8", "no ready while full", in_ready, 0);
    out_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "idle after take",
          {in_ready, out_valid}, 2'b10);
    finish_run();
  end
endmodule